// File: doc/BRIEF.md
# Serial Flash Write-Enable and Region Protection Controller

This block guards every modifying operation of a small serial flash. It keeps the write-enable latch, a three-bit protection field and a status-lock bit. A command decoder in front of it sends one-cycle strobes. When a program, erase or status write arrives, the block answers the next cycle with exactly one of two pulses, grant or deny. The SPI shifter and the array sequencer act on that answer. Shifting and array timing stay outside the block.

A request is granted only when all of these hold: the latch is set, the status register is not locked, and the target lies outside the read-only region that the protection field selects. The lock needs both the lock bit set and the write-protect pin low. A granted request clears the latch. A denied request leaves every bit unchanged, so software can read the status and retry.

The default geometry is a 64 KiB array of sixteen 4 KiB sectors, all in one block. The sector index is the top four address bits.

Top module: `fwp_ctrl`

## Requirements
- R1: Power-on reset (`por_n` low) clears the latch, the protection field and the lock bit, and holds grant and deny at 0.
- R2: A write-enable strobe sets `wel_o` one cycle later. A write-disable strobe clears it one cycle later. Neither strobe pulses grant or deny.
- R3: A status write, program or erase that arrives while `wel_o` is 0 is denied. It changes neither the status bits nor the latch.
- R4: A granted status write loads `wrsr_bp_i` into `bp_o` and `wrsr_srp_i` into `srp_o`, and clears `wel_o`, all in the same cycle as the grant pulse.
- R5: When `srp_o` is 1 and `wp_n_i` is 0, a status write is denied. `bp_o`, `srp_o` and `wel_o` keep their values.
- R6: When `srp_o` is 0, the level of `wp_n_i` has no effect on whether a status write is granted.
- R7: The protection field sets the read-only region. Code 0 protects nothing. Codes 1, 2, 3 and 4 protect the highest 1, 2, 4 and 8 sectors. Codes 5 to 7 protect the whole array. A page program or sector erase whose address falls in the region is denied and keeps `wel_o`. Outside the region it is granted and clears `wel_o`.
- R8: A block erase is denied if any sector of the block that holds `addr_i` is protected. Otherwise it is granted and clears `wel_o`.
- R9: A chip erase is denied when `bp_o` is non-zero. Otherwise it is granted and clears `wel_o`.
- R10: Each modify request gives exactly one one-cycle pulse, on `grant_o` or on `deny_o`, in the cycle after the strobe. Neither pulse occurs without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| wrsr_i | input | 1 | Status-write request strobe |
| wrsr_bp_i | input | 3 | Protection field carried by a status write |
| wrsr_srp_i | input | 1 | Lock bit carried by a status write |
| prog_i | input | 1 | Page program request strobe |
| sect_erase_i | input | 1 | Sector erase request strobe |
| blk_erase_i | input | 1 | Block erase request strobe |
| chip_erase_i | input | 1 | Chip erase request strobe |
| wp_n_i | input | 1 | Write-protect pin, active low |
| addr_i | input | 16 | Target byte address of a program or erase |
| wel_o | output | 1 | Write-enable latch |
| bp_o | output | 3 | Protection field |
| srp_o | output | 1 | Status-lock bit |
| grant_o | output | 1 | Request accepted (one-cycle pulse) |
| deny_o | output | 1 | Request refused (one-cycle pulse) |

## Verification
The assertions assume that the decoder raises at most one command strobe per cycle and holds each strobe for a single cycle. An input assertion checks this assumption. The bench drives every command as a single strobe between two falling edges, always separated, so the precedence between simultaneous strobes is never exercised. The bench changes `addr_i`, `wp_n_i` and the status-write fields only on falling edges, so they are stable at the rising edge that samples the strobe.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

    typedef enum logic [2:0] {
        REQ_NONE = 3'd0,
        REQ_STAT = 3'd1,
        REQ_PROG = 3'd2,
        REQ_SECT = 3'd3,
        REQ_BLK  = 3'd4,
        REQ_CHIP = 3'd5
    } req_e;

    typedef struct packed {
        logic grant;
        logic deny;
    } verdict_t;

endpackage

// File: rtl/fwp_region_chk.sv
module fwp_region_chk #(
    parameter int ADDR_W            = 16,
    parameter int SECTORS           = 16,
    parameter int SECTORS_PER_BLOCK = 16,
    parameter int BP_W              = 3
) (
    input  logic [BP_W-1:0]   bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              sect_hit_o,
    output logic              blk_hit_o,
    output logic              any_prot_o
);
    localparam int SECT_W = $clog2(SECTORS);
    localparam logic [SECT_W-1:0] BLK_MASK = SECT_W'(SECTORS_PER_BLOCK - 1);

    logic [SECT_W:0]   prot_cnt;
    logic [SECT_W:0]   low_bound;
    logic [SECT_W-1:0] sect_idx;
    logic [SECT_W-1:0] blk_last;

    assign sect_idx = addr_i[ADDR_W-1 -: SECT_W];
    assign blk_last = sect_idx | BLK_MASK;

    // Number of protected sectors at the top of the array.
    always_comb begin
        if (bp_i == '0) begin
            prot_cnt = '0;
        end else if (int'(bp_i) - 1 >= SECT_W) begin
            prot_cnt = (SECT_W+1)'(SECTORS);
        end else begin
            prot_cnt = (SECT_W+1)'(1) << (int'(bp_i) - 1);
        end
        low_bound = (SECT_W+1)'(SECTORS) - prot_cnt;
    end

    assign any_prot_o = (prot_cnt != '0);
    assign sect_hit_o = any_prot_o && ({1'b0, sect_idx} >= low_bound);
    assign blk_hit_o  = any_prot_o && ({1'b0, blk_last} >= low_bound);

endmodule

// File: rtl/fwp_decide.sv
module fwp_decide
    import fwp_pkg::*;
(
    input  req_e     req_i,
    input  logic     wel_i,
    input  logic     sr_locked_i,
    input  logic     sect_hit_i,
    input  logic     blk_hit_i,
    input  logic     any_prot_i,
    output verdict_t verdict_o
);
    logic blocked;

    always_comb begin
        case (req_i)
            REQ_STAT: blocked = sr_locked_i;
            REQ_PROG,
            REQ_SECT: blocked = sect_hit_i;
            REQ_BLK:  blocked = blk_hit_i;
            REQ_CHIP: blocked = any_prot_i;
            default:  blocked = 1'b0;
        endcase
        verdict_o.grant = 1'b0;
        verdict_o.deny  = 1'b0;
        if (req_i != REQ_NONE) begin
            if (wel_i && !blocked) begin
                verdict_o.grant = 1'b1;
            end else begin
                verdict_o.deny = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fwp_ctrl.sv
module fwp_ctrl
    import fwp_pkg::*;
#(
    parameter int ADDR_W            = 16,
    parameter int SECTORS           = 16,
    parameter int SECTORS_PER_BLOCK = 16,
    parameter int BP_W              = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic [BP_W-1:0]   wrsr_bp_i,
    input  logic              wrsr_srp_i,
    input  logic              prog_i,
    input  logic              sect_erase_i,
    input  logic              blk_erase_i,
    input  logic              chip_erase_i,
    input  logic              wp_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              wel_o,
    output logic [BP_W-1:0]   bp_o,
    output logic              srp_o,
    output logic              grant_o,
    output logic              deny_o
);
    typedef struct packed {
        logic            wel;
        logic [BP_W-1:0] bp;
        logic            srp;
        logic            grant;
        logic            deny;
    } state_t;

    state_t   st_d, st_q;
    req_e     req;
    verdict_t verdict;
    logic     sect_hit, blk_hit, any_prot, sr_locked, any_req;

    always_comb begin
        if (wrsr_i)            req = REQ_STAT;
        else if (prog_i)       req = REQ_PROG;
        else if (sect_erase_i) req = REQ_SECT;
        else if (blk_erase_i)  req = REQ_BLK;
        else if (chip_erase_i) req = REQ_CHIP;
        else                   req = REQ_NONE;
    end

    assign any_req   = wrsr_i | prog_i | sect_erase_i | blk_erase_i | chip_erase_i;
    assign sr_locked = st_q.srp & ~wp_n_i;

    fwp_region_chk #(
        .ADDR_W            (ADDR_W),
        .SECTORS           (SECTORS),
        .SECTORS_PER_BLOCK (SECTORS_PER_BLOCK),
        .BP_W              (BP_W)
    ) u_region (
        .bp_i       (st_q.bp),
        .addr_i     (addr_i),
        .sect_hit_o (sect_hit),
        .blk_hit_o  (blk_hit),
        .any_prot_o (any_prot)
    );

    fwp_decide u_decide (
        .req_i       (req),
        .wel_i       (st_q.wel),
        .sr_locked_i (sr_locked),
        .sect_hit_i  (sect_hit),
        .blk_hit_i   (blk_hit),
        .any_prot_i  (any_prot),
        .verdict_o   (verdict)
    );

    always_comb begin
        st_d       = st_q;
        st_d.grant = verdict.grant;
        st_d.deny  = verdict.deny;
        if (wren_i) begin
            st_d.wel = 1'b1;
        end else if (wrdi_i) begin
            st_d.wel = 1'b0;
        end
        if (verdict.grant) begin
            st_d.wel = 1'b0;
            if (req == REQ_STAT) begin
                st_d.bp  = wrsr_bp_i;
                st_d.srp = wrsr_srp_i;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wel_o   = st_q.wel;
    assign bp_o    = st_q.bp;
    assign srp_o   = st_q.srp;
    assign grant_o = st_q.grant;
    assign deny_o  = st_q.deny;

    // Input contract: at most one command strobe per cycle.
    p_single_cmd_r10: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({wren_i, wrdi_i, wrsr_i, prog_i, sect_erase_i, blk_erase_i, chip_erase_i}));

    p_grant_deny_excl_r10: assert property (@(posedge clk) disable iff (!por_n)
        !(grant_o && deny_o));

    p_req_answered_r10: assert property (@(posedge clk) disable iff (!por_n)
        any_req |=> (grant_o || deny_o));

    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!por_n)
        !any_req |=> !(grant_o || deny_o));

    p_wren_sets_r2: assert property (@(posedge clk) disable iff (!por_n)
        wren_i |=> wel_o);

    p_grant_needs_wel_r3: assert property (@(posedge clk) disable iff (!por_n)
        any_req && !wel_o |=> deny_o && !wel_o);

    p_grant_clears_wel_r4: assert property (@(posedge clk) disable iff (!por_n)
        grant_o |-> !wel_o);

    p_locked_stable_r5: assert property (@(posedge clk) disable iff (!por_n)
        wrsr_i && srp_o && !wp_n_i |=> deny_o && $stable(bp_o) && $stable(srp_o));

    p_chip_guard_r9: assert property (@(posedge clk) disable iff (!por_n)
        chip_erase_i && (bp_o != '0) |=> deny_o);

endmodule

// File: tb/fwp_ctrl_test.sv
`timescale 1ns/1ps
module fwp_ctrl_test;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        wren, wrdi, wrsr, wsrp, prog, se, be, ce, wp_n;
    logic [2:0]  wbp;
    logic [15:0] addr;
    logic        wel, srp, grant, deny;
    logic [2:0]  bp;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fwp_ctrl uut (
        .clk(clk), .por_n(por_n),
        .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr),
        .wrsr_bp_i(wbp), .wrsr_srp_i(wsrp),
        .prog_i(prog), .sect_erase_i(se), .blk_erase_i(be), .chip_erase_i(ce),
        .wp_n_i(wp_n), .addr_i(addr),
        .wel_o(wel), .bp_o(bp), .srp_o(srp), .grant_o(grant), .deny_o(deny)
    );

    // cmd: 0 none, 1 wren, 2 wrdi, 3 status write, 4 program, 5 sector, 6 block, 7 chip
    typedef struct packed {
        logic [2:0]  cmd;
        logic [15:0] addr;
        logic        wp_n;
        logic [2:0]  wbp;
        logic        wsrp;
        logic        eg;
        logic        ed;
        logic        ewel;
        logic [2:0]  ebp;
        logic        esrp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VEC [NV] = '{
        '{3'd4, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 4'd3}, // R3
        '{3'd3, 16'h0000, 1'b1, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 4'd3}, // R3
        '{3'd1, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 4'd2}, // R2
        '{3'd2, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 4'd2}, // R2
        '{3'd1, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 4'd2},
        '{3'd3, 16'h0000, 1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 4'd6}, // R6, R4
        '{3'd1, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 4'd2},
        '{3'd4, 16'hF123, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 4'd7}, // R7
        '{3'd5, 16'hE000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 4'd7},
        '{3'd5, 16'hDFFF, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 4'd7},
        '{3'd1, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 4'd2},
        '{3'd6, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 4'd8}, // R8
        '{3'd7, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 4'd9}, // R9
        '{3'd3, 16'h0000, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 4'd4}, // R4
        '{3'd1, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 4'd2},
        '{3'd7, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 4'd9}, // R9
        '{3'd1, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 4'd2},
        '{3'd3, 16'h0000, 1'b0, 3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 1'b1, 4'd5}, // R5
        '{3'd3, 16'h0000, 1'b1, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 3'd4, 1'b1, 4'd4},
        '{3'd1, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 1'b1, 4'd2},
        '{3'd4, 16'h7FFF, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 1'b1, 4'd7},
        '{3'd1, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 1'b1, 4'd2},
        '{3'd4, 16'h8000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 1'b1, 4'd7},
        '{3'd3, 16'h0000, 1'b1, 3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 3'd5, 1'b1, 4'd4},
        '{3'd1, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5, 1'b1, 4'd2},
        '{3'd4, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 1'b1, 4'd7},
        '{3'd3, 16'h0000, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 4'd4},
        '{3'd1, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 4'd2},
        '{3'd4, 16'hEFFF, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 4'd7},
        '{3'd1, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 4'd2},
        '{3'd4, 16'hF000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 4'd7},
        '{3'd0, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 4'd10}, // R10
        '{3'd2, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 4'd2}
    };

    task automatic clear_cmds();
        {wren, wrdi, wrsr, prog, se, be, ce} = '0;
    endtask

    task automatic drive(input logic [2:0] c, input logic [15:0] a, input logic w,
                         input logic [2:0] b, input logic s);
        clear_cmds();
        addr = a; wp_n = w; wbp = b; wsrp = s;
        case (c)
            3'd1: wren = 1'b1;
            3'd2: wrdi = 1'b1;
            3'd3: wrsr = 1'b1;
            3'd4: prog = 1'b1;
            3'd5: se   = 1'b1;
            3'd6: be   = 1'b1;
            3'd7: ce   = 1'b1;
            default: ;
        endcase
    endtask

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic eg, input logic ed,
                             input logic ew, input logic [2:0] eb, input logic es);
        check(tag, "grant", int'(grant), int'(eg));
        check(tag, "deny",  int'(deny),  int'(ed));
        check(tag, "wel",   int'(wel),   int'(ew));
        check(tag, "bp",    int'(bp),    int'(eb));
        check(tag, "srp",   int'(srp),   int'(es));
    endtask

    initial begin
        clear_cmds();
        addr = '0; wp_n = 1'b1; wbp = '0; wsrp = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1", 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
        por_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].cmd, VEC[i].addr, VEC[i].wp_n, VEC[i].wbp, VEC[i].wsrp);
            @(negedge clk);
            check_all($sformatf("R%0d vec%0d", VEC[i].rq, i),
                      VEC[i].eg, VEC[i].ed, VEC[i].ewel, VEC[i].ebp, VEC[i].esrp);
        end
        clear_cmds();

        // R5: status locked; toggling wp_n alone changes nothing
        drive(3'd3, 16'h0, 1'b1, 3'd3, 1'b1); // state bp1 srp0, wel0 -> need wel first
        @(negedge clk);
        check_all("R3 status write without wel", 1'b0, 1'b1, 1'b0, 3'd1, 1'b0);
        drive(3'd1, 16'h0, 1'b1, 3'd0, 1'b0);
        @(negedge clk);
        drive(3'd3, 16'h0, 1'b1, 3'd3, 1'b1);
        @(negedge clk);
        check_all("R4 load bp3 srp1", 1'b1, 1'b0, 1'b0, 3'd3, 1'b1);
        drive(3'd0, 16'h0, 1'b0, 3'd0, 1'b0);
        @(negedge clk);
        check_all("R5 wp_n low idle", 1'b0, 1'b0, 1'b0, 3'd3, 1'b1);
        // bp3: top 4 sectors (C000 up); block erase covers all
        drive(3'd1, 16'h0, 1'b1, 3'd0, 1'b0);
        @(negedge clk);
        drive(3'd5, 16'hBFFF, 1'b1, 3'd0, 1'b0);
        @(negedge clk);
        check_all("R7 sector below bp3 region", 1'b1, 1'b0, 1'b0, 3'd3, 1'b1);
        drive(3'd1, 16'h0, 1'b1, 3'd0, 1'b0);
        @(negedge clk);
        drive(3'd5, 16'hC000, 1'b1, 3'd0, 1'b0);
        @(negedge clk);
        check_all("R7 sector at bp3 boundary", 1'b0, 1'b1, 1'b1, 3'd3, 1'b1);
        drive(3'd0, 16'h0, 1'b1, 3'd0, 1'b0);
        @(negedge clk);
        check_all("R10 no pulse after deny", 1'b0, 1'b0, 1'b1, 3'd3, 1'b1);

        // R1: reset in mid-run clears everything
        por_n = 1'b0;
        @(negedge clk);
        check_all("R1 mid-run reset", 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
        por_n = 1'b1;
        @(negedge clk);
        // R8: with no protection, block erase is granted
        drive(3'd1, 16'h0, 1'b1, 3'd0, 1'b0);
        @(negedge clk);
        drive(3'd6, 16'h1234, 1'b1, 3'd0, 1'b0);
        @(negedge clk);
        check_all("R8 block erase unprotected", 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
        clear_cmds();
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual=running expected=finished");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule